// File: doc/BRIEF.md
# Misaligned Word Access Splitter

This block sits between a requester and a 16-bit memory bus that has a separate, active-low enable for each byte lane. The requester asks for a byte or a word, read or write, at any byte address. An aligned word, or any single byte, goes out as one bus cycle. A word that starts at an odd address is carried out as two one-byte bus cycles. The block steers the write bytes onto the correct lanes, or gathers the two read bytes into one result. The requester sees one completed word access, with a single done pulse.

The bus side uses a request/ready handshake, so the memory may insert any number of wait states. Each bus cycle lasts until the memory returns ready. A misaligned word therefore occupies the bus for twice as long as an aligned one.

The controller has four states:

- `ST_IDLE`: waits for a request.
- `ST_ALIGNED`: runs the single bus cycle of a byte or an even word.
- `ST_SPLIT_FIRST`: accesses the odd address on the high lane.
- `ST_SPLIT_SECOND`: accesses the following even address on the low lane.

The transitions are:

- **accept-single**: `ST_IDLE` to `ST_ALIGNED`.
- **accept-split**: `ST_IDLE` to `ST_SPLIT_FIRST`.
- **first-done**: `ST_SPLIT_FIRST` to `ST_SPLIT_SECOND`.
- **finish**: `ST_ALIGNED` or `ST_SPLIT_SECOND` back to `ST_IDLE`.
- **wait**: any bus state stays where it is while ready is low.

Top module: `misalign_bus_splitter`

## Requirements
- R1: During and right after reset, req_ready is 1 while bus_req and rsp_done are 0.
- R2: A word request at an even address A gives exactly one bus cycle. That cycle has bus_addr=A, bus_lane_n=2'b00 (both lanes enabled), and the whole word on bus_wdata for a write.
- R3: A byte request gives exactly one bus cycle at its address. At an even address, bus_lane_n=2'b10 and the byte travels on bits 7:0. At an odd address, bus_lane_n=2'b01 and the byte travels on bits 15:8. A byte read returns that lane's byte in rsp_rdata[7:0], with bits 15:8 equal to 0.
- R4: A word request at an odd address A gives exactly two bus cycles. The first cycle has bus_addr=A and bus_lane_n=2'b01. The second cycle has bus_addr=A+1 (modulo 2^AW) and bus_lane_n=2'b10.
- R5: For a misaligned read, rsp_rdata[7:0] is the high-lane byte of the first cycle, and rsp_rdata[15:8] is the low-lane byte of the second cycle.
- R6: For a misaligned write, the first cycle carries wdata[7:0] on bus_wdata[15:8], and the second cycle carries wdata[15:8] on bus_wdata[7:0]. In every cycle, any lane that is not enabled is driven to 0, and reads drive bus_wdata to 0.
- R7: rsp_done pulses high for exactly one clock, one clock after the handshake of the final bus cycle. In that same clock rsp_rdata holds the result, which is 0 for writes.
- R8: req_ready is 0 from the clock after a request is accepted until rsp_done. Requests presented during this time start no bus cycle.
- R9: While bus_req is high and bus_ready is low, bus_req, bus_addr, bus_lane_n and bus_wdata hold steady. Each bus cycle therefore keeps bus_req high for the wait count plus one clock, so a misaligned word costs twice the bus time of an aligned one.
- R10: bus_write equals the request's write flag for every bus cycle of that request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Requester presents a request |
| req_ready | output | 1 | Block can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_word | input | 1 | 1 = word, 0 = byte |
| req_addr | input | AW | Byte address |
| req_wdata | input | 16 | Write data (byte in bits 7:0) |
| rsp_done | output | 1 | One-clock completion pulse |
| rsp_rdata | output | 16 | Assembled read result |
| bus_req | output | 1 | Bus cycle request |
| bus_write | output | 1 | Bus cycle direction |
| bus_addr | output | AW | Bus byte address |
| bus_lane_n | output | 2 | Active-low lane enables, bit 1 high lane, bit 0 low lane |
| bus_wdata | output | 16 | Bus write data |
| bus_rdata | input | 16 | Bus read data |
| bus_ready | input | 1 | Memory completes the current bus cycle |

## Verification
The assertions check on every cycle the behaviours that hold at all times:

- The bus signals stay steady during wait states.
- A lane combination is never empty, and it always matches address bit 0.
- Bus activity starts only after an accepted request.
- rsp_done lasts one clock and follows a bus handshake.

Only the bench's scenarios can show that:

- each kind of request produces the right number of bus cycles, with the right addresses;
- the data bytes are steered and reassembled in little-endian order;
- the address wraps at the top of the space;
- bus time doubles for misaligned words under varying wait states.

// File: rtl/mbs_pkg.sv
package mbs_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ALIGNED,
        ST_SPLIT_FIRST,
        ST_SPLIT_SECOND
    } mbs_state_e;

    // active-low lane enables: bit 1 = high lane, bit 0 = low lane
    localparam logic [1:0] LANES_BOTH = 2'b00;
    localparam logic [1:0] LANE_LOW   = 2'b10;
    localparam logic [1:0] LANE_HIGH  = 2'b01;
    localparam logic [1:0] LANES_NONE = 2'b11;

    typedef struct packed {
        logic write;
        logic word;
    } mbs_op_t;

endpackage

// File: rtl/mbs_lane_plan.sv
module mbs_lane_plan #(
    parameter int AW = 20
) (
    input  logic [AW-1:0] base_addr,
    input  logic          word,
    input  logic          second,
    output logic [AW-1:0] cyc_addr,
    output logic [1:0]    lane_n
);
    import mbs_pkg::*;

    always_comb begin
        cyc_addr = second ? base_addr + AW'(1) : base_addr;
        if (!word) begin
            lane_n = cyc_addr[0] ? LANE_HIGH : LANE_LOW;
        end else if (!base_addr[0]) begin
            lane_n = LANES_BOTH;
        end else begin
            lane_n = second ? LANE_LOW : LANE_HIGH;
        end
    end

endmodule

// File: rtl/mbs_data_steer.sv
module mbs_data_steer #(
    parameter int BW = 8,
    localparam int DW = 2 * BW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          active,
    input  logic          write,
    input  logic          split,
    input  logic          second,
    input  logic [1:0]    lane_n,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] bus_wdata,
    input  logic [DW-1:0] bus_rdata,
    input  logic          hs,
    input  logic          last,
    output logic [DW-1:0] rsp_rdata
);
    import mbs_pkg::*;

    logic [BW-1:0] wr_byte;
    logic [BW-1:0] lo_hold_q;
    logic [DW-1:0] result;

    // write steering
    always_comb begin
        wr_byte   = (split && second) ? wdata[DW-1:BW] : wdata[BW-1:0];
        bus_wdata = '0;
        if (active && write) begin
            unique case (lane_n)
                LANES_BOTH: bus_wdata = wdata;
                LANE_LOW:   bus_wdata = {{BW{1'b0}}, wr_byte};
                LANE_HIGH:  bus_wdata = {wr_byte, {BW{1'b0}}};
                default:    bus_wdata = '0;
            endcase
        end
    end

    // read assembly
    always_comb begin
        if (write) begin
            result = '0;
        end else if (split) begin
            result = {bus_rdata[BW-1:0], lo_hold_q};
        end else begin
            unique case (lane_n)
                LANES_BOTH: result = bus_rdata;
                LANE_HIGH:  result = {{BW{1'b0}}, bus_rdata[DW-1:BW]};
                default:    result = {{BW{1'b0}}, bus_rdata[BW-1:0]};
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_hold_q <= '0;
            rsp_rdata <= '0;
        end else begin
            if (hs && split && !second) begin
                lo_hold_q <= bus_rdata[DW-1:BW];
            end
            if (last) begin
                rsp_rdata <= result;
            end
        end
    end

endmodule

// File: rtl/misalign_bus_splitter.sv
module misalign_bus_splitter #(
    parameter int AW = 20,
    parameter int BW = 8,
    localparam int DW = 2 * BW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic          req_write,
    input  logic          req_word,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    output logic          rsp_done,
    output logic [DW-1:0] rsp_rdata,
    output logic          bus_req,
    output logic          bus_write,
    output logic [AW-1:0] bus_addr,
    output logic [1:0]    bus_lane_n,
    output logic [DW-1:0] bus_wdata,
    input  logic [DW-1:0] bus_rdata,
    input  logic          bus_ready
);
    import mbs_pkg::*;

    mbs_state_e    state_q, state_d;
    mbs_op_t       op_q;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] wdata_q;
    logic          done_q;

    logic          accept;
    logic          active;
    logic          second;
    logic          split;
    logic          hs;
    logic          last;
    logic [AW-1:0] plan_addr;
    logic [1:0]    plan_lane_n;

    assign accept = req_valid && (state_q == ST_IDLE);

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) begin
                    state_d = (req_word && req_addr[0]) ? ST_SPLIT_FIRST : ST_ALIGNED;
                end
            end
            ST_ALIGNED:      if (bus_ready) state_d = ST_IDLE;
            ST_SPLIT_FIRST:  if (bus_ready) state_d = ST_SPLIT_SECOND;
            ST_SPLIT_SECOND: if (bus_ready) state_d = ST_IDLE;
            default:         state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // request capture and done pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q    <= '0;
            addr_q  <= '0;
            wdata_q <= '0;
            done_q  <= 1'b0;
        end else begin
            if (accept) begin
                op_q.write <= req_write;
                op_q.word  <= req_word;
                addr_q     <= req_addr;
                wdata_q    <= req_wdata;
            end
            done_q <= last;
        end
    end

    // outputs
    always_comb begin
        active     = (state_q != ST_IDLE);
        second     = (state_q == ST_SPLIT_SECOND);
        split      = (state_q == ST_SPLIT_FIRST) || (state_q == ST_SPLIT_SECOND);
        hs         = active && bus_ready;
        last       = bus_ready && ((state_q == ST_ALIGNED) || (state_q == ST_SPLIT_SECOND));
        req_ready  = !active;
        bus_req    = active;
        bus_write  = active && op_q.write;
        bus_addr   = plan_addr;
        bus_lane_n = active ? plan_lane_n : LANES_NONE;
        rsp_done   = done_q;
    end

    mbs_lane_plan #(.AW(AW)) u_plan (
        .base_addr (addr_q),
        .word      (op_q.word),
        .second    (second),
        .cyc_addr  (plan_addr),
        .lane_n    (plan_lane_n)
    );

    mbs_data_steer #(.BW(BW)) u_steer (
        .clk       (clk),
        .rst_n     (rst_n),
        .active    (active),
        .write     (op_q.write),
        .split     (split),
        .second    (second),
        .lane_n    (plan_lane_n),
        .wdata     (wdata_q),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .hs        (hs),
        .last      (last),
        .rsp_rdata (rsp_rdata)
    );

    // R9
    hold_during_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && !bus_ready |=> bus_req && $stable(bus_addr) && $stable(bus_lane_n)
                                  && $stable(bus_wdata) && $stable(bus_write));

    // R2
    lane_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req |-> bus_lane_n != LANES_NONE);

    // R4
    odd_addr_high_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && bus_addr[0] |-> bus_lane_n == LANE_HIGH);

    // R8
    start_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_req) |-> $past(req_valid && req_ready));

    // R7
    done_after_handshake_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |-> $past(bus_req && bus_ready) && !bus_req);

    // R7
    done_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done);

endmodule

// File: tb/misalign_bus_splitter_tb.sv
module misalign_bus_splitter_tb;
    localparam int AW = 20;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic          req_write = 1'b0;
    logic          req_word = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          rsp_done;
    logic [DW-1:0] rsp_rdata;
    logic          bus_req;
    logic          bus_write;
    logic [AW-1:0] bus_addr;
    logic [1:0]    bus_lane_n;
    logic [DW-1:0] bus_wdata;
    logic [DW-1:0] bus_rdata = '0;
    logic          bus_ready = 1'b0;

    int checks = 0;
    int errors = 0;
    int wait_cfg = 0;
    int wcnt = 0;
    int log_n = 0;
    logic [AW-1:0] log_addr [0:3];
    logic [1:0]    log_lane [0:3];
    logic [DW-1:0] log_wd   [0:3];
    logic          log_wr   [0:3];

    always #4 clk = ~clk;

    misalign_bus_splitter #(.AW(AW)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_word(req_word), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
        .bus_req(bus_req), .bus_write(bus_write), .bus_addr(bus_addr),
        .bus_lane_n(bus_lane_n), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_ready(bus_ready)
    );

    function automatic logic [7:0] pat(input logic [AW-1:0] a);
        return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'hA5;
    endfunction

    // memory model with configurable wait states
    always @(negedge clk) begin
        if (bus_ready) wcnt = 0;
        if (rst_n && bus_req) begin
            if (wcnt >= wait_cfg) begin
                bus_ready = 1'b1;
                bus_rdata = {pat(bus_addr | AW'(1)), pat(bus_addr & ~AW'(1))};
                if (log_n < 4) begin
                    log_addr[log_n] = bus_addr;
                    log_lane[log_n] = bus_lane_n;
                    log_wd[log_n]   = bus_wdata;
                    log_wr[log_n]   = bus_write;
                end
                log_n++;
            end else begin
                bus_ready = 1'b0;
                wcnt++;
            end
        end else begin
            bus_ready = 1'b0;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic int exp_ncyc(input logic word, input logic [AW-1:0] a);
        return (word && a[0]) ? 2 : 1;
    endfunction

    function automatic logic [1:0] exp_lane(input logic word, input logic [AW-1:0] a, input int k);
        if (!word) return a[0] ? 2'b01 : 2'b10;
        if (!a[0]) return 2'b00;
        return (k == 0) ? 2'b01 : 2'b10;
    endfunction

    function automatic logic [DW-1:0] exp_wd(input logic wr, input logic word,
                                             input logic [AW-1:0] a, input logic [DW-1:0] d, input int k);
        if (!wr) return '0;
        if (word && !a[0]) return d;
        if (word) return (k == 0) ? {d[7:0], 8'h00} : {8'h00, d[15:8]};
        return a[0] ? {d[7:0], 8'h00} : {8'h00, d[7:0]};
    endfunction

    function automatic logic [DW-1:0] exp_rd(input logic wr, input logic word, input logic [AW-1:0] a);
        if (wr) return '0;
        if (word) return {pat(a + AW'(1)), pat(a)};
        return {8'h00, pat(a)};
    endfunction

    task automatic run(input logic wr, input logic word, input logic [AW-1:0] a,
                       input logic [DW-1:0] d, input int waits);
        int busy = 0;
        int cyc = 0;
        bit ready_ok = 1'b1;
        bit done_seen = 1'b0;
        int n;
        string rq;
        wait_cfg = waits;
        @(negedge clk);
        log_n = 0;
        req_valid = 1'b1; req_write = wr; req_word = word; req_addr = a; req_wdata = d;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        req_addr = ~a; // R8: stray values while busy must not matter
        while (cyc < 200) begin
            if (rsp_done) begin done_seen = 1'b1; break; end
            if (req_ready) ready_ok = 1'b0;
            if (bus_req) busy++;
            cyc++;
            @(negedge clk);
        end
        n = exp_ncyc(word, a);
        rq = word ? (a[0] ? "R4" : "R2") : "R3";
        chk(done_seen, "R7", "done seen", 32'(done_seen), 32'd1);
        chk(ready_ok, "R8", "ready low while busy", 32'(ready_ok), 32'd1);
        chk(log_n == n, rq, "bus cycle count", 32'(log_n), 32'(n));
        chk(busy == n * (waits + 1), "R9", "bus time", 32'(busy), 32'(n * (waits + 1)));
        for (int k = 0; k < n && k < log_n; k++) begin
            chk(log_addr[k] == ((k == 0) ? a : a + AW'(1)), rq, "bus addr",
                32'(log_addr[k]), 32'((k == 0) ? a : a + AW'(1)));
            chk(log_lane[k] == exp_lane(word, a, k), rq, "lane enables",
                32'(log_lane[k]), 32'(exp_lane(word, a, k)));
            chk(log_wd[k] == exp_wd(wr, word, a, d, k), "R6", "bus wdata",
                32'(log_wd[k]), 32'(exp_wd(wr, word, a, d, k)));
            chk(log_wr[k] == wr, "R10", "bus write flag", 32'(log_wr[k]), 32'(wr));
        end
        chk(rsp_rdata == exp_rd(wr, word, a), (word && a[0]) ? "R5" : "R7", "result",
            32'(rsp_rdata), 32'(exp_rd(wr, word, a)));
        @(negedge clk);
        chk(!rsp_done, "R7", "done one clock", 32'(rsp_done), 32'd0);
    endtask

    initial begin
        int unused_seed;
        unused_seed = $urandom(32'h1234_5678);
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(req_ready && !bus_req && !rsp_done, "R1", "reset outputs",
            {29'd0, req_ready, bus_req, rsp_done}, 32'h4);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready && !bus_req && !rsp_done, "R1", "after reset",
            {29'd0, req_ready, bus_req, rsp_done}, 32'h4);

        run(1'b0, 1'b1, 20'h00010, 16'h0000, 0);   // R2 even word read
        run(1'b1, 1'b1, 20'h00A42, 16'hBEEF, 1);   // R2 even word write
        run(1'b0, 1'b1, 20'h00011, 16'h0000, 0);   // R4 R5 odd word read
        run(1'b1, 1'b1, 20'h00ABD, 16'h1234, 0);   // R4 R6 odd word write
        run(1'b0, 1'b0, 20'h00300, 16'h0000, 2);   // R3 even byte read
        run(1'b0, 1'b0, 20'h00301, 16'h0000, 2);   // R3 odd byte read
        run(1'b1, 1'b0, 20'h00302, 16'h55C3, 0);   // R3 even byte write
        run(1'b1, 1'b0, 20'h00303, 16'h55C3, 0);   // R3 odd byte write
        run(1'b0, 1'b1, 20'hFFFFF, 16'h0000, 2);   // R4 wrap read
        run(1'b1, 1'b1, 20'hFFFFF, 16'hA55A, 3);   // R4 wrap write
        run(1'b1, 1'b1, 20'h01235, 16'h9876, 3);   // R9 long waits

        for (int i = 0; i < 300; i++) begin
            run(1'($urandom), 1'($urandom), AW'($urandom), DW'($urandom), int'($urandom_range(0, 3)));
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog R7: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule